// File: doc/BRIEF.md
# Strap-Loaded Configuration Target on a Two-Wire Serial Bus

This block is a small target on a two-wire serial bus (I2C). It holds the settings of a signal-conditioning device whose channels come in two groups. Each group has one equalizer select, one output swing select and one emphasis select, and every channel in the group uses the same values. During reset the registers copy the strap pins. After reset a bus master may rewrite them, but only while the lock input is low.

The block samples both bus lines with its own system clock. It detects start and stop conditions from the sampled lines. The seven-bit bus address mixes fixed bits with three select pins. Every transfer begins at register offset 0 because the block keeps no offset pointer that a master can set. In a write, the first byte after the address is a fill byte and is thrown away. The bytes after it fill the registers in order. A read returns the registers in order from offset 0 until the master withholds its acknowledge. The block only pulls SDA low and never holds SCL.

Top module: `cfg_i2c_target`

## Requirements
- R1: The block answers only the address with bits 6..0 equal to 1, 1, `addr_sel_i[2]`, 0, 0, `addr_sel_i[1]`, `addr_sel_i[0]`. The eighth bit selects the direction: 1 means read and 0 means write. For any other address it gives no acknowledge on the address byte or on the bytes that follow, and SDA stays released.
- R2: Every byte is 8 bits long, sent most significant bit first, and followed by one acknowledge bit.
- R3: After a matching address byte and after each byte received from the master, SDA is pulled low for the whole high time of the acknowledge clock. The block changes its SDA drive only while SCL is low.
- R4: In a write, the first byte after the address is discarded. The next bytes go to offset 0, then offset 1, and so on, whatever value the discarded byte had.
- R5: A read starts at offset 0 and returns one byte for each acknowledge given by the master. A not-acknowledge from the master ends the read and releases SDA.
- R6: Byte 0 holds group A and byte 1 holds group B. In each byte, bits 7:6 are swing, bits 5:3 are emphasis and bits 2:0 are equalizer select. The register outputs show these fields, with group A in the low slice of each output vector.
- R7: Every start or stop returns the offset to 0. A short write followed by a second write therefore lands at offset 0 again.
- R8: While `rst_n` is low, each group's registers take the strap inputs of that group.
- R9: While `mode_i` is high, write bytes are still acknowledged but no register changes.
- R10: Offsets beyond the last register read back as 0x00. Writes to those offsets are acknowledged and have no effect.
- R11: A start condition at any point aborts the transfer under way, and a partial byte is not written. The block then matches an address again. A stop returns the block to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Active-low reset; loads the strap values |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| addr_sel_i | input | 3 | Address select pins for bits 4, 1 and 0 |
| mode_i | input | 1 | High blocks bus writes to the registers |
| strap_eq_i | input | 6 | Equalizer straps, 3 bits per group, group A low |
| strap_swing_i | input | 4 | Swing straps, 2 bits per group, group A low |
| strap_emph_i | input | 6 | Emphasis straps, 3 bits per group, group A low |
| eq_o | output | 6 | Equalizer selects, 3 bits per group, group A low |
| swing_o | output | 4 | Swing selects, 2 bits per group, group A low |
| emph_o | output | 6 | Emphasis selects, 3 bits per group, group A low |

## Verification
The hardest case to reach is a start condition that arrives in the middle of a data byte. The bench stops a write after four data bits, raises SDA while SCL is low, and issues a new start with a read address. The read must then return the old byte 0, and the register outputs must still hold their previous values. Checking the acknowledge hold is also delicate, because the bench has to sample the open-drain line near both ends of the acknowledge high time.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_FILL,
        ST_WDATA,
        ST_ACK,
        ST_TX,
        ST_MACK
    } fsm_state_e;
endpackage

// File: rtl/cfg_i2c_sampler.sv
module cfg_i2c_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s_o,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sync;
        logic [SYNC_STAGES-1:0] sda_sync;
        logic                   scl_prev;
        logic                   sda_prev;
    } smp_t;

    smp_t smp_d, smp_q;
    logic scl_now, sda_now;

    assign scl_now = smp_q.scl_sync[SYNC_STAGES-1];
    assign sda_now = smp_q.sda_sync[SYNC_STAGES-1];

    always_comb begin
        smp_d          = smp_q;
        smp_d.scl_sync = {smp_q.scl_sync[SYNC_STAGES-2:0], scl_i};
        smp_d.sda_sync = {smp_q.sda_sync[SYNC_STAGES-2:0], sda_i};
        smp_d.scl_prev = scl_now;
        smp_d.sda_prev = sda_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '1;
        end else begin
            smp_q <= smp_d;
        end
    end

    // SDA edges while SCL is high on both samples mark bus conditions.
    assign scl_s_o    = scl_now;
    assign sda_s_o    = sda_now;
    assign scl_rise_o = scl_now & ~smp_q.scl_prev;
    assign scl_fall_o = ~scl_now & smp_q.scl_prev;
    assign start_o    = scl_now & smp_q.scl_prev & smp_q.sda_prev & ~sda_now;
    assign stop_o     = scl_now & smp_q.scl_prev & ~smp_q.sda_prev & sda_now;
endmodule

// File: rtl/cfg_i2c_fsm.sv
module cfg_i2c_fsm
    import cfg_i2c_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [6:0]        own_addr_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [PTR_W-1:0]  rd_ptr_o,
    output logic              wr_en_o,
    output logic [PTR_W-1:0]  wr_ptr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              sda_oe_o,
    output fsm_state_e        state_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    typedef struct packed {
        fsm_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shreg;
        logic              rw;
        logic              fill_done;
        logic              mack;
        logic              sda_oe;
        logic [PTR_W-1:0]  ptr;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic [PTR_W-1:0] ptr_inc;

    assign ptr_inc = (fsm_q.ptr == '1) ? fsm_q.ptr : fsm_q.ptr + 1'b1;

    always_comb begin
        fsm_d     = fsm_q;
        wr_en_o   = 1'b0;
        wr_ptr_o  = fsm_q.ptr;
        wr_data_o = fsm_q.shreg;
        if (start_i) begin
            fsm_d.state     = ST_ADDR;
            fsm_d.cnt       = '0;
            fsm_d.sda_oe    = 1'b0;
            fsm_d.ptr       = '0;
            fsm_d.fill_done = 1'b0;
        end else if (stop_i) begin
            fsm_d.state  = ST_IDLE;
            fsm_d.sda_oe = 1'b0;
            fsm_d.ptr    = '0;
        end else begin
            unique case (fsm_q.state)
                ST_ADDR, ST_FILL, ST_WDATA: begin
                    if (scl_rise_i && fsm_q.cnt != CNT_FULL) begin
                        fsm_d.shreg = {fsm_q.shreg[BYTE_W-2:0], sda_s_i};
                        fsm_d.cnt   = fsm_q.cnt + 1'b1;
                    end else if (scl_fall_i && fsm_q.cnt == CNT_FULL) begin
                        fsm_d.cnt = '0;
                        if (fsm_q.state == ST_ADDR) begin
                            if (fsm_q.shreg[BYTE_W-1:1] == own_addr_i) begin
                                fsm_d.rw     = fsm_q.shreg[0];
                                fsm_d.state  = ST_ACK;
                                fsm_d.sda_oe = 1'b1;
                            end else begin
                                fsm_d.state = ST_IDLE;
                            end
                        end else begin
                            if (fsm_q.state == ST_FILL) begin
                                fsm_d.fill_done = 1'b1;
                            end else begin
                                wr_en_o   = 1'b1;
                                fsm_d.ptr = ptr_inc;
                            end
                            fsm_d.state  = ST_ACK;
                            fsm_d.sda_oe = 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        if (fsm_q.rw) begin
                            fsm_d.sda_oe = ~rd_data_i[BYTE_W-1];
                            fsm_d.shreg  = {rd_data_i[BYTE_W-2:0], 1'b0};
                            fsm_d.cnt    = CNT_W'(1);
                            fsm_d.ptr    = ptr_inc;
                            fsm_d.state  = ST_TX;
                        end else begin
                            fsm_d.sda_oe = 1'b0;
                            fsm_d.cnt    = '0;
                            fsm_d.state  = fsm_q.fill_done ? ST_WDATA : ST_FILL;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall_i) begin
                        if (fsm_q.cnt != CNT_FULL) begin
                            fsm_d.sda_oe = ~fsm_q.shreg[BYTE_W-1];
                            fsm_d.shreg  = {fsm_q.shreg[BYTE_W-2:0], 1'b0};
                            fsm_d.cnt    = fsm_q.cnt + 1'b1;
                        end else begin
                            fsm_d.sda_oe = 1'b0;
                            fsm_d.mack   = 1'b0;
                            fsm_d.state  = ST_MACK;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise_i) begin
                        fsm_d.mack = ~sda_s_i;
                    end
                    if (scl_fall_i) begin
                        if (fsm_q.mack) begin
                            fsm_d.sda_oe = ~rd_data_i[BYTE_W-1];
                            fsm_d.shreg  = {rd_data_i[BYTE_W-2:0], 1'b0};
                            fsm_d.cnt    = CNT_W'(1);
                            fsm_d.ptr    = ptr_inc;
                            fsm_d.state  = ST_TX;
                        end else begin
                            fsm_d.state = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{state: ST_IDLE, cnt: '0, shreg: '0, rw: 1'b0,
                       fill_done: 1'b0, mack: 1'b0, sda_oe: 1'b0, ptr: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign rd_ptr_o = fsm_q.ptr;
    assign sda_oe_o = fsm_q.sda_oe;
    assign state_o  = fsm_q.state;
endmodule

// File: rtl/cfg_i2c_regfile.sv
module cfg_i2c_regfile
    import cfg_i2c_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter int EQ_W       = 3,
    parameter int EMPH_W     = 3,
    parameter int SWING_W    = 2,
    parameter int PTR_W      = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          mode_i,
    input  logic [NUM_GROUPS*EQ_W-1:0]    strap_eq_i,
    input  logic [NUM_GROUPS*SWING_W-1:0] strap_swing_i,
    input  logic [NUM_GROUPS*EMPH_W-1:0]  strap_emph_i,
    input  logic                          wr_en_i,
    input  logic [PTR_W-1:0]              wr_ptr_i,
    input  logic [BYTE_W-1:0]             wr_data_i,
    input  logic [PTR_W-1:0]              rd_ptr_i,
    output logic [BYTE_W-1:0]             rd_data_o,
    output logic [NUM_GROUPS*EQ_W-1:0]    eq_o,
    output logic [NUM_GROUPS*SWING_W-1:0] swing_o,
    output logic [NUM_GROUPS*EMPH_W-1:0]  emph_o
);
    localparam int FIELD_W = SWING_W + EMPH_W + EQ_W;

    typedef struct packed {
        logic [SWING_W-1:0] swing;
        logic [EMPH_W-1:0]  emph;
        logic [EQ_W-1:0]    eq;
    } grp_cfg_t;

    grp_cfg_t cfg_d     [NUM_GROUPS];
    grp_cfg_t cfg_q     [NUM_GROUPS];
    grp_cfg_t strap_cfg [NUM_GROUPS];

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign strap_cfg[g].swing = strap_swing_i[g*SWING_W +: SWING_W];
        assign strap_cfg[g].emph  = strap_emph_i[g*EMPH_W +: EMPH_W];
        assign strap_cfg[g].eq    = strap_eq_i[g*EQ_W +: EQ_W];
        assign swing_o[g*SWING_W +: SWING_W] = cfg_q[g].swing;
        assign emph_o[g*EMPH_W +: EMPH_W]    = cfg_q[g].emph;
        assign eq_o[g*EQ_W +: EQ_W]          = cfg_q[g].eq;
    end

    always_comb begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
            cfg_d[g] = cfg_q[g];
            if (wr_en_i && !mode_i && wr_ptr_i == PTR_W'(g)) begin
                cfg_d[g] = wr_data_i[FIELD_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
                cfg_q[g] <= strap_cfg[g];
            end
        end else begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
                cfg_q[g] <= cfg_d[g];
            end
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (rd_ptr_i == PTR_W'(g)) begin
                rd_data_o = BYTE_W'(cfg_q[g]);
            end
        end
    end
endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
    import cfg_i2c_pkg::*;
#(
    parameter int NUM_GROUPS  = 2,
    parameter int EQ_W        = 3,
    parameter int EMPH_W      = 3,
    parameter int SWING_W     = 2,
    parameter int SYNC_STAGES = 2,
    parameter int PTR_W       = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          scl_i,
    input  logic                          sda_i,
    output logic                          sda_oe_o,
    input  logic [2:0]                    addr_sel_i,
    input  logic                          mode_i,
    input  logic [NUM_GROUPS*EQ_W-1:0]    strap_eq_i,
    input  logic [NUM_GROUPS*SWING_W-1:0] strap_swing_i,
    input  logic [NUM_GROUPS*EMPH_W-1:0]  strap_emph_i,
    output logic [NUM_GROUPS*EQ_W-1:0]    eq_o,
    output logic [NUM_GROUPS*SWING_W-1:0] swing_o,
    output logic [NUM_GROUPS*EMPH_W-1:0]  emph_o
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [6:0]        own_addr;
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [BYTE_W-1:0] rd_data, wr_data;
    logic              wr_en;
    fsm_state_e        fsm_state;

    // Fixed high bits, pin bit 4, fixed zeros, pin bits 1 and 0.
    assign own_addr = {2'b11, addr_sel_i[2], 2'b00, addr_sel_i[1], addr_sel_i[0]};

    cfg_i2c_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s_o(scl_s), .sda_s_o(sda_s), .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall), .start_o(start_det), .stop_o(stop_det)
    );

    cfg_i2c_fsm #(.PTR_W(PTR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s_i(sda_s), .scl_rise_i(scl_rise),
        .scl_fall_i(scl_fall), .start_i(start_det), .stop_i(stop_det),
        .own_addr_i(own_addr), .rd_data_i(rd_data), .rd_ptr_o(rd_ptr),
        .wr_en_o(wr_en), .wr_ptr_o(wr_ptr), .wr_data_o(wr_data),
        .sda_oe_o(sda_oe_o), .state_o(fsm_state)
    );

    cfg_i2c_regfile #(
        .NUM_GROUPS(NUM_GROUPS), .EQ_W(EQ_W), .EMPH_W(EMPH_W),
        .SWING_W(SWING_W), .PTR_W(PTR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .strap_eq_i(strap_eq_i), .strap_swing_i(strap_swing_i),
        .strap_emph_i(strap_emph_i), .wr_en_i(wr_en), .wr_ptr_i(wr_ptr),
        .wr_data_i(wr_data), .rd_ptr_i(rd_ptr), .rd_data_o(rd_data),
        .eq_o(eq_o), .swing_o(swing_o), .emph_o(emph_o)
    );
endmodule

// File: rtl/cfg_i2c_target_chk.sv
module cfg_i2c_target_chk
    import cfg_i2c_pkg::*;
#(
    parameter int CFG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_i,
    input logic             sda_oe,
    input logic             scl_s,
    input logic             start_det,
    input logic             stop_det,
    input fsm_state_e       state,
    input logic [CFG_W-1:0] cfg_bus
);
    logic past_ok_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    assert_drive_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    assert_ack_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK && scl_s) |-> sda_oe);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    assert_start_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (!sda_oe && state == ST_ADDR));

    assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && state == ST_IDLE));

    assert_mode_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && mode_i && $past(mode_i)) |-> $stable(cfg_bus));
endmodule

bind cfg_i2c_target cfg_i2c_target_chk #(
    .CFG_W(NUM_GROUPS*(EQ_W+SWING_W+EMPH_W))
) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sda_oe(sda_oe_o),
    .scl_s(scl_s), .start_det(start_det), .stop_det(stop_det),
    .state(fsm_state), .cfg_bus({swing_o, emph_o, eq_o})
);

// File: tb/cfg_i2c_target_tb.sv
module cfg_i2c_target_tb;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic mode = 1'b0;
    logic [2:0] addr_sel = 3'b101;
    logic sda_oe;
    logic [5:0] eq;
    logic [3:0] swing;
    logic [5:0] emph;
    wire sda_line = sda_m & ~sda_oe;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] mA, mB;

    always #5 clk = ~clk;

    cfg_i2c_target u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .addr_sel_i(addr_sel), .mode_i(mode),
        .strap_eq_i({3'b011, 3'b101}), .strap_swing_i({2'b10, 2'b01}),
        .strap_emph_i({3'b110, 3'b010}),
        .eq_o(eq), .swing_o(swing), .emph_o(emph)
    );

    // addr7, expected ack, fill byte, byte 0, byte 1
    localparam logic [31:0] VECS [5] = '{
        {7'h71, 1'b1, 8'h00, 8'h12, 8'h34},
        {7'h71, 1'b1, 8'hFF, 8'hA7, 8'h5C},
        {7'h70, 1'b0, 8'h00, 8'hEE, 8'hEE},
        {7'h79, 1'b0, 8'h12, 8'h01, 8'h02},
        {7'h71, 1'b1, 8'h55, 8'h00, 8'hFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wc(Q); scl_m = 1'b1; wc(Q);
        sda_m = 1'b0; wc(Q); scl_m = 1'b0; wc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wc(Q); scl_m = 1'b1; wc(Q); sda_m = 1'b1; wc(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wc(Q); scl_m = 1'b1; wc(2*Q); scl_m = 1'b0; wc(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wc(Q); scl_m = 1'b1; wc(Q); b = sda_line;
        wc(Q); scl_m = 1'b0; wc(Q);
    endtask

    task automatic write_byte(input logic [7:0] v, output logic ack, output logic held);
        logic a0, a1, a2;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        sda_m = 1'b1; wc(Q); scl_m = 1'b1;
        wc(1); a0 = sda_line; wc(Q-1); a1 = sda_line; wc(Q-1); a2 = sda_line;
        wc(1); scl_m = 1'b0; wc(Q);
        ack = ~a1;
        held = (a0 == a1) && (a1 == a2);
    endtask

    task automatic read_byte(input logic nack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) recv_bit(v[i]);
        send_bit(nack);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] fill, input int n,
                            input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                            output logic a_addr, output logic a_all, output logic h_all);
        logic ak, hd;
        logic [7:0] bytes [3];
        bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
        bus_start();
        write_byte({a, 1'b0}, a_addr, h_all);
        write_byte(fill, a_all, hd);
        h_all = h_all & hd;
        for (int i = 0; i < n; i++) begin
            write_byte(bytes[i], ak, hd);
            a_all = a_all & ak;
            h_all = h_all & hd;
        end
        bus_stop();
    endtask

    task automatic do_read(input logic [6:0] a, output logic a_addr,
                           output logic [7:0] r0, output logic [7:0] r1, output logic [7:0] r2);
        logic hd;
        bus_start();
        write_byte({a, 1'b1}, a_addr, hd);
        read_byte(1'b0, r0);
        read_byte(1'b0, r1);
        read_byte(1'b1, r2);
        bus_stop();
    endtask

    function automatic logic [15:0] outs();
        return {swing[3:2], emph[5:3], eq[5:3], swing[1:0], emph[2:0], eq[2:0]};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic aa, al, ha;
        logic [7:0] r0, r1, r2;
        logic [31:0] v;
        mA = 8'h55; mB = 8'hB3;
        wc(5);
        check("R8 outputs follow straps in reset", 32'(outs()), {16'h0, mB, mA});
        rst_n = 1'b1;
        wc(5);
        check("R8 strap values after reset", 32'(outs()), {16'h0, mB, mA});
        check("R8 SDA released after reset", 32'(sda_oe), 32'h0);
        do_read(7'h71, aa, r0, r1, r2);
        check("R5 read address acknowledged", 32'(aa), 32'h1);
        check("R5 read byte0 strap", 32'(r0), 32'(mA));
        check("R2 read byte1 strap", 32'(r1), 32'(mB));
        check("R5 SDA released after master nack", 32'(sda_oe), 32'h0);

        for (int k = 0; k < 5; k++) begin
            v = VECS[k];
            do_write(v[31:25], v[23:16], 2, v[15:8], v[7:0], 8'h00, aa, al, ha);
            check("R1 address ack", 32'(aa), 32'(v[24]));
            if (v[24]) begin
                check("R4 fill and data acks", 32'(al), 32'h1);
                check("R3 ack held through high time", 32'(ha), 32'h1);
                mA = v[15:8]; mB = v[7:0];
            end else begin
                check("R1 no data ack after mismatch", 32'(al), 32'h0);
            end
            check("R6 outputs after write", 32'(outs()), {16'h0, mB, mA});
            do_read(7'h71, aa, r0, r1, r2);
            check("R2 readback byte0", 32'(r0), 32'(mA));
            check("R5 readback byte1", 32'(r1), 32'(mB));
            check("R10 beyond last reads zero", 32'(r2), 32'h0);
        end

        // R9: lock pin high, writes acknowledged but ignored
        mode = 1'b1;
        do_write(7'h71, 8'h00, 2, 8'h9A, 8'h6B, 8'h00, aa, al, ha);
        check("R9 locked write acknowledged", 32'({aa, al}), 32'h3);
        check("R9 locked write no change", 32'(outs()), {16'h0, mB, mA});
        mode = 1'b0;

        // R10: third data byte lands beyond the map
        do_write(7'h71, 8'hC3, 3, 8'h0F, 8'hF0, 8'h99, aa, al, ha);
        mA = 8'h0F; mB = 8'hF0;
        check("R10 extra byte acknowledged", 32'({aa, al}), 32'h3);
        check("R10 extra byte no effect", 32'(outs()), {16'h0, mB, mA});
        do_read(7'h71, aa, r0, r1, r2);
        check("R10 extra offset reads zero", 32'(r2), 32'h0);

        // R7: short writes each restart at offset 0
        do_write(7'h71, 8'h00, 1, 8'h11, 8'h00, 8'h00, aa, al, ha);
        do_write(7'h71, 8'h00, 1, 8'h22, 8'h00, 8'h00, aa, al, ha);
        mA = 8'h22;
        check("R7 second short write at offset 0", 32'(outs()), {16'h0, mB, mA});

        // R11: repeated start in the middle of a data byte
        bus_start();
        write_byte({7'h71, 1'b0}, aa, ha);
        write_byte(8'h00, al, ha);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_start();
        write_byte({7'h71, 1'b1}, aa, ha);
        check("R11 address after repeated start", 32'(aa), 32'h1);
        read_byte(1'b1, r0);
        bus_stop();
        check("R11 read from offset 0 after abort", 32'(r0), 32'(mA));
        check("R11 partial byte not written", 32'(outs()), {16'h0, mB, mA});
        check("R11 SDA released after stop", 32'(sda_oe), 32'h0);

        // R1: address pins select a different address
        addr_sel = 3'b010;
        wc(4);
        do_write(7'h71, 8'h00, 2, 8'h44, 8'h45, 8'h00, aa, al, ha);
        check("R1 old address ignored", 32'({aa, al}), 32'h0);
        check("R1 old address no write", 32'(outs()), {16'h0, mB, mA});
        do_write(7'h62, 8'h00, 2, 8'h44, 8'h45, 8'h00, aa, al, ha);
        mA = 8'h44; mB = 8'h45;
        check("R1 new address acknowledged", 32'({aa, al}), 32'h3);
        check("R6 new address write", 32'(outs()), {16'h0, mB, mA});

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule